// File: doc/BRIEF.md
# Prioritized Interrupt Pending Arbiter

This block collects a vector of external interrupt request lines for a single processor. It keeps a pending flag for every line and picks one winner by priority. Each line has a recorded level, an enable bit and a trigger-type bit. A line that rises marks its interrupt pending when the interrupt is edge-typed or enabled. A line that falls only updates the recorded level. Pending flags are cleared through a one-cycle clear port, which stands in for an acknowledge path.

Every cycle the block searches the enabled, pending interrupts for the numerically lowest priority value. Two thresholds are applied to the winner. The priority mask decides whether the winner's ID is reported at all. A strict comparison against the running priority decides whether the processor interrupt line is raised. When nothing qualifies, or when either the global enable or the processor-interface enable is off, the reserved ID 1023 is reported. The reported IDs are internal IDs: external line n appears as ID n+32, and IDs 0 to 31 are kept for internal sources that this block does not carry.

All configuration inputs are captured into registers. The search runs combinationally on that registered state, and the output is registered again.

Top module: `prio_irq_arb`

## Requirements
- R1: External line n (0 ≤ n < NUM_IRQ−32) is reported as ID n+32. `id_o` only ever holds 1023 or a value in 32..NUM_IRQ−1.
- R2: Driving a line to the level it already has changes nothing. A line held high after its pending flag was cleared does not become pending again.
- R3: A low-to-high change on a line records the level as high. It sets the pending flag only if that line's `trig_edge_i` bit is 1 (edge-typed) or its `en_i` bit is 1. A rise on a disabled, level-typed line leaves nothing pending, even after the line is later enabled.
- R4: A high-to-low change on a line clears only the recorded level. The pending flag is kept, and the interrupt stays selectable.
- R5: While `glb_en_i` or `cpu_en_i` is 0, `irq_o` is 0 and `id_o` is 1023.
- R6: Among interrupts that are both enabled and pending, the winner has the numerically lowest 8-bit priority (priority of line n in `prio_i[8n+7:8n]`). On equal priority the lowest ID wins.
- R7: The winner's ID is reported only when its priority ≤ `pmask_i`, otherwise 1023 is reported. With no candidate, 1023 is reported for every mask value, including 0xFF.
- R8: `irq_o` is 1 only when an ID is reported (R7) and the winner's priority is strictly less than `run_pri_i`.
- R9: A cycle with `clr_valid_i`=1 and `clr_id_i` in 32..NUM_IRQ−1 clears that ID's pending flag. Other `clr_id_i` values are ignored. If the same line rises in the same cycle, the rise wins and the flag stays set.
- R10: While reset is asserted, and on release, `irq_o` is 0 and `id_o` is 1023. Pending flags, levels and enables are cleared, the running priority reads 0xFF and the mask reads 0x00.
- R11: A change on the inputs first shows on the outputs after the second rising clock edge. The output is unchanged after the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| glb_en_i | input | 1 | Global distributor enable |
| cpu_en_i | input | 1 | Processor-interface enable |
| en_i | input | NUM_IRQ-32 | Per-line interrupt enable |
| trig_edge_i | input | NUM_IRQ-32 | Per-line trigger type, 1 = edge-typed |
| prio_i | input | 8*(NUM_IRQ-32) | Per-line priority, line n in bits 8n+7:8n |
| pmask_i | input | 8 | Priority mask for reporting |
| run_pri_i | input | 8 | Running priority for raising the line |
| irq_line_i | input | NUM_IRQ-32 | External interrupt request lines |
| clr_valid_i | input | 1 | Clear-pending strobe |
| clr_id_i | input | 10 | ID whose pending flag is cleared |
| irq_o | output | 1 | Interrupt request to the processor |
| id_o | output | 10 | Currently reported interrupt ID, 1023 = none |

## Verification
A wrong pending flag shows up as a wrong ID on `id_o` two edges after the event that should have set or kept it, but only while that line wins the search. The sweeps therefore isolate one or two candidate lines at a time, so that each flag can be seen on its own. A wrong priority comparison or tie-break changes the reported ID in the same two-edge window. A threshold error shows as `irq_o` or `id_o` disagreeing at exactly the boundary values of the mask and the running priority. A clear that misses or hits the wrong line is seen when the next winner is reported.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int ID_W     = 10;
  localparam int PRIO_W   = 8;
  localparam int ID_BASE  = 32;
  localparam logic [ID_W-1:0] ID_NONE = 10'd1023;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_q = sync_q[1];
endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track
  import irq_arb_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_i,
  input  logic [LINES-1:0] en_i,
  input  logic [LINES-1:0] trig_edge_i,
  input  logic             clr_valid_i,
  input  logic [ID_W-1:0]  clr_id_i,
  output logic [LINES-1:0] pend_o
);
  logic [LINES-1:0] lvl_q, lvl_d, pend_q, pend_d, rise, clr_hit;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam logic [ID_W-1:0] MY_ID = ID_W'(ID_BASE + g);
    assign clr_hit[g] = clr_valid_i && (clr_id_i == MY_ID);
    assign rise[g]    = line_i[g] && !lvl_q[g];
  end

  always_comb begin
    lvl_d  = line_i;
    pend_d = (pend_q & ~clr_hit) | (rise & (trig_edge_i | en_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      pend_q <= '0;
    end else begin
      lvl_q  <= lvl_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_best_pick.sv
module irq_best_pick
  import irq_arb_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic [LINES-1:0]        cand_i,
  input  logic [LINES*PRIO_W-1:0] prio_i,
  output logic [PRIO_W:0]         best_prio_o,
  output logic [ID_W-1:0]         best_id_o
);
  always_comb begin
    best_prio_o = {1'b1, {PRIO_W{1'b0}}};
    best_id_o   = ID_NONE;
    for (int i = 0; i < LINES; i++) begin
      if (cand_i[i] && ({1'b0, prio_i[i*PRIO_W +: PRIO_W]} < best_prio_o)) begin
        best_prio_o = {1'b0, prio_i[i*PRIO_W +: PRIO_W]};
        best_id_o   = ID_W'(ID_BASE + i);
      end
    end
  end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  localparam int LINES  = NUM_IRQ - ID_BASE
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    glb_en_i,
  input  logic                    cpu_en_i,
  input  logic [LINES-1:0]        en_i,
  input  logic [LINES-1:0]        trig_edge_i,
  input  logic [LINES*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]       pmask_i,
  input  logic [PRIO_W-1:0]       run_pri_i,
  input  logic [LINES-1:0]        irq_line_i,
  input  logic                    clr_valid_i,
  input  logic [ID_W-1:0]         clr_id_i,
  output logic                    irq_o,
  output logic [ID_W-1:0]         id_o
);
  logic rst_q;
  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  // configuration capture
  logic                    glb_q, cpu_q;
  logic [LINES-1:0]        en_q, edge_q;
  logic [LINES*PRIO_W-1:0] prio_q;
  logic [PRIO_W-1:0]       mask_q, run_q;
  logic                    cfg_ce;
  assign cfg_ce = 1'b1;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      glb_q  <= 1'b0;
      cpu_q  <= 1'b0;
      en_q   <= '0;
      edge_q <= '0;
      prio_q <= '0;
      mask_q <= '0;
      run_q  <= '1;
    end else if (cfg_ce) begin
      glb_q  <= glb_en_i;
      cpu_q  <= cpu_en_i;
      en_q   <= en_i;
      edge_q <= trig_edge_i;
      prio_q <= prio_i;
      mask_q <= pmask_i;
      run_q  <= run_pri_i;
    end
  end

  logic [LINES-1:0] pend;
  irq_pend_track #(.LINES(LINES)) u_pend (
    .clk(clk), .rst_n(rst_q), .line_i(irq_line_i), .en_i(en_q),
    .trig_edge_i(edge_q), .clr_valid_i(clr_valid_i), .clr_id_i(clr_id_i),
    .pend_o(pend)
  );

  logic [PRIO_W:0]  best_prio;
  logic [ID_W-1:0]  best_id;
  irq_best_pick #(.LINES(LINES)) u_pick (
    .cand_i(pend & en_q), .prio_i(prio_q),
    .best_prio_o(best_prio), .best_id_o(best_id)
  );

  // output stage
  logic            on, pass_mask, irq_d;
  logic [ID_W-1:0] id_d;
  logic            irq_q;
  logic [ID_W-1:0] id_q;

  always_comb begin
    on        = glb_q && cpu_q;
    pass_mask = on && (best_prio <= {1'b0, mask_q});
    irq_d     = pass_mask && (best_prio < {1'b0, run_q});
    id_d      = pass_mask ? best_id : ID_NONE;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      irq_q <= 1'b0;
      id_q  <= ID_NONE;
    end else begin
      irq_q <= irq_d;
      id_q  <= id_d;
    end
  end

  assign irq_o = irq_q;
  assign id_o  = id_q;
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  localparam int LINES  = NUM_IRQ - ID_BASE
) (
  input logic             clk,
  input logic             rst_q,
  input logic             glb_q,
  input logic             cpu_q,
  input logic [LINES-1:0] pend,
  input logic [PRIO_W:0]  best_prio,
  input logic [PRIO_W-1:0] run_q,
  input logic             clr_valid_i,
  input logic [ID_W-1:0]  clr_id_i,
  input logic             irq_o,
  input logic [ID_W-1:0]  id_o
);
  logic [LINES-1:0] clr_mask;
  always_comb begin
    for (int i = 0; i < LINES; i++)
      clr_mask[i] = clr_valid_i && (clr_id_i == ID_W'(ID_BASE + i));
  end

  AST_ID_LEGAL: assert property (@(posedge clk) disable iff (!rst_q)
    (id_o == ID_NONE) || ((id_o >= ID_W'(ID_BASE)) && (id_o < ID_W'(NUM_IRQ)))); // R1

  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    !(glb_q && cpu_q) |=> (!irq_o && (id_o == ID_NONE))); // R5

  AST_IRQ_HAS_ID: assert property (@(posedge clk) disable iff (!rst_q)
    irq_o |-> (id_o != ID_NONE)); // R8

  AST_IRQ_STRICT: assert property (@(posedge clk) disable iff (!rst_q)
    irq_o |-> ($past(best_prio) < {1'b0, $past(run_q)})); // R8

  AST_PEND_DROP_ONLY_BY_CLEAR: assert property (@(posedge clk) disable iff (!rst_q)
    1'b1 |=> (($past(pend) & ~pend & ~$past(clr_mask)) == '0)); // R4
endmodule

bind prio_irq_arb irq_arb_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_q(rst_q), .glb_q(glb_q), .cpu_q(cpu_q), .pend(pend),
  .best_prio(best_prio), .run_q(run_q), .clr_valid_i(clr_valid_i),
  .clr_id_i(clr_id_i), .irq_o(irq_o), .id_o(id_o)
);

// File: tb/sim_prio_irq_arb.sv
`timescale 1ns/1ps
module sim_prio_irq_arb;
  localparam int NUM_IRQ = 64;
  localparam int L = NUM_IRQ - 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n, glb_en_i, cpu_en_i, clr_valid_i;
  logic [L-1:0]   en_i, trig_edge_i, irq_line_i;
  logic [L*8-1:0] prio_i;
  logic [7:0]     pmask_i, run_pri_i;
  logic [9:0]     clr_id_i;
  logic           irq_o;
  logic [9:0]     id_o;

  prio_irq_arb #(.NUM_IRQ(NUM_IRQ)) u0 (
    .clk(clk), .rst_n(rst_n), .glb_en_i(glb_en_i), .cpu_en_i(cpu_en_i),
    .en_i(en_i), .trig_edge_i(trig_edge_i), .prio_i(prio_i), .pmask_i(pmask_i),
    .run_pri_i(run_pri_i), .irq_line_i(irq_line_i), .clr_valid_i(clr_valid_i),
    .clr_id_i(clr_id_i), .irq_o(irq_o), .id_o(id_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [L-1:0] m_pend, m_lvl;

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic void expect_out(output logic ei, output logic [9:0] eid);
    int bp = 256, bi = 1023;
    for (int i = 0; i < L; i++)
      if (en_i[i] && m_pend[i] && int'(prio_i[i*8 +: 8]) < bp) begin
        bp = int'(prio_i[i*8 +: 8]); bi = i + 32;
      end
    if (!(glb_en_i && cpu_en_i) || bp > int'(pmask_i)) begin
      ei = 1'b0; eid = 10'd1023;
    end else begin
      eid = 10'(bi); ei = (bp < int'(run_pri_i));
    end
  endfunction

  task automatic chk_val(string tag, logic ei, logic [9:0] eid);
    checks++;
    if (irq_o !== ei || id_o !== eid) begin
      errors++;
      $display("FAIL %s irq=%0b id=%0d expected irq=%0b id=%0d", tag, irq_o, id_o, ei, eid);
    end
  endtask

  task automatic chk(string tag);
    logic ei; logic [9:0] eid;
    expect_out(ei, eid);
    chk_val(tag, ei, eid);
  endtask

  task automatic model_lines(logic [L-1:0] nv);
    for (int i = 0; i < L; i++) begin
      if (nv[i] && !m_lvl[i] && (trig_edge_i[i] || en_i[i])) m_pend[i] = 1'b1;
    end
    m_lvl = nv;
  endtask

  task automatic set_lines(logic [L-1:0] nv);
    model_lines(nv);
    irq_line_i = nv;
    settle();
  endtask

  task automatic clear_id(logic [9:0] id);
    clr_valid_i = 1'b1; clr_id_i = id;
    if (id >= 32 && id < NUM_IRQ) m_pend[id - 32] = 1'b0;
    @(negedge clk);
    clr_valid_i = 1'b0;
    settle();
  endtask

  task automatic clear_all();
    for (int k = 32; k < NUM_IRQ; k++) begin
      clr_valid_i = 1'b1; clr_id_i = 10'(k);
      @(negedge clk);
    end
    clr_valid_i = 1'b0;
    m_pend = '0;
    settle();
  endtask

  task automatic set_prio(int n, int p);
    prio_i[n*8 +: 8] = 8'(p);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int pv[5] = '{0, 1, 127, 254, 255};
    rst_n = 1'b0; glb_en_i = 1'b1; cpu_en_i = 1'b1; en_i = '1; trig_edge_i = '1;
    prio_i = '0; pmask_i = 8'hFF; run_pri_i = 8'hFF; irq_line_i = '0;
    clr_valid_i = 1'b0; clr_id_i = '0; m_pend = '0; m_lvl = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk_val("R10 in reset", 1'b0, 10'd1023);
    rst_n = 1'b1;
    @(negedge clk);
    chk_val("R10 at release", 1'b0, 10'd1023);
    settle();
    chk("R10 after release");

    // R1 sweep: each line alone maps to n+32
    for (int n = 0; n < L; n++) set_prio(n, (n * 37) % 255);
    settle();
    for (int n = 0; n < L; n++) begin
      clear_all();
      set_lines('0);
      set_lines(L'(1) << n);
      chk_val("R1 map", 1'b1, 10'(n + 32));
    end

    // R6 two-candidate priority sweep with tie to lowest ID
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++) begin
        set_prio(3, pv[a]); set_prio(9, pv[b]);
        set_lines('0);
        clear_all();
        set_lines((L'(1) << 3) | (L'(1) << 9));
        chk("R6 prio pair");
      end
    set_prio(3, 5); set_prio(9, 5); settle();
    chk_val("R6 tie lowest id", 1'b1, 10'd35);

    // R7 mask boundary
    set_lines('0); clear_all();
    set_prio(5, 8'h40); set_lines(L'(1) << 5);
    for (int m = 8'h3E; m <= 8'h42; m++) begin
      pmask_i = 8'(m); settle();
      chk("R7 mask sweep");
    end
    pmask_i = 8'h3F; settle();
    chk_val("R7 below mask", 1'b0, 10'd1023);
    pmask_i = 8'hFF;

    // R8 running priority boundary
    for (int r = 8'h3F; r <= 8'h42; r++) begin
      run_pri_i = 8'(r); settle();
      chk("R8 run sweep");
    end
    run_pri_i = 8'h40; settle();
    chk_val("R8 equal run no irq", 1'b0, 10'd37);
    run_pri_i = 8'hFF;

    // R7 no candidate with full mask; prio 0xFF candidate
    set_lines('0); clear_all();
    chk_val("R7 none full mask", 1'b0, 10'd1023);
    set_prio(20, 8'hFF); set_lines(L'(1) << 20);
    chk_val("R7 prio ff reported R8 no irq", 1'b0, 10'd52);

    // R5 gates
    set_prio(20, 8'h10); settle();
    for (int g = 0; g < 4; g++) begin
      glb_en_i = g[0]; cpu_en_i = g[1]; settle();
      chk("R5 gate combo");
    end

    // R11 latency
    set_lines('0); clear_all();
    set_prio(6, 8'h02);
    settle();
    model_lines(L'(1) << 6); irq_line_i = L'(1) << 6;
    @(posedge clk); @(negedge clk);
    chk_val("R11 after one edge", 1'b0, 10'd1023);
    @(posedge clk); @(negedge clk);
    chk_val("R11 after two edges", 1'b1, 10'd38);

    // R2 same level re-drive after clear
    clear_id(10'd38);
    set_lines(L'(1) << 6);
    chk_val("R2 held high no repend", 1'b0, 10'd1023);

    // R4 fall keeps pending
    set_lines('0); clear_all();
    set_prio(8, 8'h07); set_lines(L'(1) << 8);
    set_lines('0);
    chk_val("R4 fall keeps pend", 1'b1, 10'd40);

    // R3 trigger/enable rules
    clear_all();
    en_i[10] = 1'b0; trig_edge_i[10] = 1'b0; set_prio(10, 1); settle();
    set_lines(L'(1) << 10);
    en_i[10] = 1'b1; settle();
    chk_val("R3 level disabled not pended", 1'b0, 10'd1023);
    set_lines('0);
    en_i[11] = 1'b0; trig_edge_i[11] = 1'b1; set_prio(11, 1); settle();
    set_lines(L'(1) << 11);
    chk_val("R3 edge pended but disabled", 1'b0, 10'd1023);
    en_i[11] = 1'b1; settle();
    chk_val("R3 edge pended shows when enabled", 1'b1, 10'd43);

    // R9 clear port
    set_lines('0); clear_all();
    set_prio(12, 3); set_prio(13, 4);
    set_lines((L'(1) << 12) | (L'(1) << 13));
    clear_id(10'd0); clear_id(10'd31); clear_id(10'd64); clear_id(10'd1023);
    chk_val("R9 out of range ignored", 1'b1, 10'd44);
    clear_id(10'd44);
    chk_val("R9 clear to next", 1'b1, 10'd45);
    set_lines(L'(1) << 13);
    set_lines((L'(1) << 12) | (L'(1) << 13));
    set_lines(L'(1) << 13);
    // rise and clear of ID 44 in the same cycle: rise wins
    clr_valid_i = 1'b1; clr_id_i = 10'd44;
    irq_line_i = (L'(1) << 12) | (L'(1) << 13);
    m_lvl = irq_line_i; m_pend[12] = 1'b1;
    @(negedge clk);
    clr_valid_i = 1'b0;
    settle();
    chk_val("R9 rise wins over clear", 1'b1, 10'd44);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule